// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address. It walks a multi-level radix tree held in memory. A request carries the effective address, the process identifier and the process-table base register.

The walker first fetches the process-table entry. The slot it reads depends on the identifier and on the table size field. From that entry it decodes the tree size, the root directory base and the root index width, and it checks the address against the tree size. It then reads one directory entry per level until one of three things happens:

- it reaches a leaf entry;
- it meets an invalid entry;
- it finds a malformed level size.

The leaf entry and the merged real address go to a separate permission checker. The walker does not judge access rights itself.

Memory is reached through a simple read port. The port raises a request pulse with an address, and the memory answers with a valid strobe and 64 bits of data, after any number of cycles. Each walk ends with a one-cycle done pulse. A one-hot error code goes with it, and the code is all zero on success. Bit numbers below count from the least significant bit (bit 63 is the MSB).

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: The process-table entry address is `{8'h00, base[55:36], (base[35:12] & ~M) | (epid[31:8] & M), epid[7:0], 4'h0}`.
  - `base` is `req_ptbase`.
  - M has its low `req_ptbase[4:0]` bits set.
  - `epid` is zero when VA bit 63 is 1, and the request identifier otherwise.
- R3: The process-table entry is decoded as follows:
  - The tree size is the 5-bit value `{E[7:5], E[62:61]}`.
  - The root base is `{E[55:8], 8'h00}`.
  - The root index width is `E[4:0]`.
  - The initial remaining shift is tree size + 19 - root width.
- R4: A segment error ends the walk with `walk_err` = 3'b010 when VA bits 63 and 62 differ. It does the same when any VA bit 31+i (i = 0..30) with i >= tree size is 1. In both cases only the process-table entry is read.
- R5: A bad-tree error ends the walk with `walk_err` = 3'b100 when the root or a directory index width is below 5, above 16, or above the remaining shift. A directory entry that passes reduces the remaining shift by its width.
- R6: A directory read address is `{8'h00, B[55:19], (B[18:3] & ~K) | (X & K), 3'b000}`.
  - B is the current level base.
  - K has the low index-width bits set.
  - X is the low 16 bits of VA[61:12] shifted right by the remaining shift.
  - Each entry is 8 bytes.
- R7: A directory entry whose valid bit (bit 63) is 0 ends the walk with `walk_err` = 3'b001.
- R8: An entry with bit 63 and the leaf bit (bit 62) set ends the walk with `walk_err` = 0. `leaf_entry` holds that entry. `real_addr` is `{8'h00, (E[55:12] & ~F) | (VA[55:12] & F), E[11:0]}`, where F has the low remaining-shift bits set.
- R9: `mem_req` is a one-cycle pulse, and no new request is raised before `mem_rvalid` answers the previous one.
- R10: The walk's handshakes behave as follows:
  - `done` is a one-cycle pulse, with `walk_err` carrying at most one set bit.
  - `req_ready` is 0 from acceptance until after `done`.
  - A request offered while busy is ignored.
  - A non-leaf entry with a width of 5..16 in bits 4:0 makes the walker descend one level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Effective address to translate |
| req_pid | input | 32 | Process identifier |
| req_ptbase | input | 64 | Process-table base register (size in bits 4:0) |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 64 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Walk finished pulse |
| walk_err | output | 3 | One-hot error: bit0 invalid, bit1 segment, bit2 bad tree |
| real_addr | output | 64 | Merged real address of the leaf |
| leaf_entry | output | 64 | Leaf entry for the permission checker |

## Verification
The hardest cases to reach from the ports depend on the tree-size field:

- the segment boundary, which moves with the tree size;
- the order in which the two tree-size fragments are joined.

A wrong join only shows up as a different root index position. The stimulus therefore uses the same address under two process-table entries. In the first, tree size 3 puts VA bit 34 outside the tree and raises a segment error. In the second, tree size 4, built from the upper fragment alone, makes that same bit a valid root index. It also makes the second level 10 bits wide, so the expected directory addresses catch a swapped join.

A leaf met at the root level exercises the merge of address bits into the real page number.

// File: rtl/rw_pkg.sv
package rw_pkg;

  localparam int unsigned VA_W    = 64;
  localparam int unsigned PID_W   = 32;
  localparam int unsigned SHIFT_W = 6;
  localparam int unsigned SIZE_W  = 5;
  localparam int unsigned ERR_W   = 3;
  localparam int unsigned SEG_GAP = 19;

  localparam logic [ERR_W-1:0] ERR_NONE = 3'b000;
  localparam logic [ERR_W-1:0] ERR_INV  = 3'b001;
  localparam logic [ERR_W-1:0] ERR_SEG  = 3'b010;
  localparam logic [ERR_W-1:0] ERR_BAD  = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRT_REQ  = 3'd1,
    ST_PRT_WAIT = 3'd2,
    ST_ROOT_CHK = 3'd3,
    ST_LVL_REQ  = 3'd4,
    ST_LVL_WAIT = 3'd5,
    ST_FINISH   = 3'd6
  } walk_state_e;

  // mask with the n low bits set, saturating at 64
  function automatic logic [63:0] low_mask(input logic [6:0] n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      m[i] = (i < int'(n));
    end
    return m;
  endfunction

endpackage

// File: rtl/rw_root_decode.sv
module rw_root_decode
  import rw_pkg::*;
#(
  parameter int unsigned IDX_MIN = 5,
  parameter int unsigned IDX_MAX = 16
) (
  input  logic [63:0]        prte,
  input  logic [VA_W-1:0]    va,
  output logic               seg_err,
  output logic               bad_tree,
  output logic [SHIFT_W-1:0] init_shift,
  output logic [55:0]        root_base,
  output logic [SIZE_W-1:0]  root_size
);

  logic [SIZE_W-1:0]  tree_size;
  logic [SHIFT_W-1:0] limit;
  logic [63:0]        tmask;
  logic [30:0]        outside;
  logic               unused_prte;

  assign tree_size = {prte[7:5], prte[62:61]};
  assign limit     = {1'b0, tree_size} + SHIFT_W'(SEG_GAP);
  assign root_size = prte[4:0];
  assign root_base = {prte[55:8], 8'h00};

  always_comb begin
    tmask   = low_mask({2'b00, tree_size});
    outside = va[61:31] & ~tmask[30:0];
    seg_err = (va[63] != va[62]) || (|outside);
  end

  assign bad_tree   = (int'(root_size) < int'(IDX_MIN)) ||
                      (int'(root_size) > int'(IDX_MAX)) ||
                      ({1'b0, root_size} > limit);
  assign init_shift = limit - {1'b0, root_size};

  assign unused_prte = ^{prte[63], prte[60:56], tmask[63:31], va[30:0]};

endmodule

// File: rtl/rw_level_decode.sv
module rw_level_decode
  import rw_pkg::*;
#(
  parameter int unsigned IDX_MIN = 5,
  parameter int unsigned IDX_MAX = 16
) (
  input  logic [63:0]        entry,
  input  logic [SHIFT_W-1:0] shift,
  output logic               ent_valid,
  output logic               ent_leaf,
  output logic               size_bad,
  output logic [SHIFT_W-1:0] next_shift,
  output logic [55:0]        next_base,
  output logic [SIZE_W-1:0]  next_size
);

  logic unused_entry;

  assign ent_valid  = entry[63];
  assign ent_leaf   = entry[62];
  assign next_size  = entry[4:0];
  assign next_base  = {entry[55:8], 8'h00};
  assign size_bad   = (int'(next_size) < int'(IDX_MIN)) ||
                      (int'(next_size) > int'(IDX_MAX)) ||
                      ({1'b0, next_size} > shift);
  assign next_shift = shift - {1'b0, next_size};

  assign unused_entry = ^{entry[61:56], entry[7:5]};

endmodule

// File: rtl/rw_addr_calc.sv
module rw_addr_calc
  import rw_pkg::*;
(
  input  logic [VA_W-1:0]    va,
  input  logic [PID_W-1:0]   pid,
  input  logic [63:0]        ptbase,
  input  logic [55:0]        lvl_base,
  input  logic [SIZE_W-1:0]  lvl_size,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [63:0]        leaf,
  output logic [63:0]        prt_addr,
  output logic [63:0]        lvl_addr,
  output logic [63:0]        real_addr
);

  logic [PID_W-1:0] epid;
  logic [63:0]      pmask;
  logic [63:0]      imask;
  logic [63:0]      fmask;
  logic [49:0]      va_pg;
  logic [49:0]      va_sh;
  logic [15:0]      idx;
  logic             unused_calc;

  assign epid  = va[63] ? '0 : pid;
  assign va_pg = va[61:12];
  assign va_sh = va_pg >> shift;
  assign idx   = va_sh[15:0];

  always_comb begin
    pmask = low_mask({2'b00, ptbase[4:0]});
    imask = low_mask({2'b00, lvl_size});
    fmask = low_mask({1'b0, shift});
  end

  // 16-byte process-table slots
  assign prt_addr = {8'h00, ptbase[55:36],
                     (ptbase[35:12] & ~pmask[23:0]) | (epid[31:8] & pmask[23:0]),
                     epid[7:0], 4'h0};

  // 8-byte directory slots
  assign lvl_addr = {8'h00, lvl_base[55:19],
                     (lvl_base[18:3] & ~imask[15:0]) | (idx & imask[15:0]),
                     3'b000};

  assign real_addr = {8'h00,
                      (leaf[55:12] & ~fmask[43:0]) | (va[55:12] & fmask[43:0]),
                      leaf[11:0]};

  assign unused_calc = ^{ptbase[63:56], ptbase[11:5], lvl_base[2:0], leaf[63:56],
                         pmask[63:24], imask[63:16], fmask[63:44], va_sh[49:16]};

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int unsigned IDX_MIN = 5,
  parameter int unsigned IDX_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [63:0]       req_ptbase,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic [ERR_W-1:0]  walk_err,
  output logic [63:0]       real_addr,
  output logic [63:0]       leaf_entry
);

  walk_state_e        state_q, state_d;
  logic [VA_W-1:0]    va_q;
  logic [PID_W-1:0]   pid_q;
  logic [63:0]        ptbase_q;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [SIZE_W-1:0]  size_q, size_d;
  logic [55:0]        base_q, base_d;
  logic [63:0]        entry_q;
  logic [ERR_W-1:0]   err_q, err_d;

  logic ld_req, ld_walk, ld_entry, ld_err;

  logic               r_seg, r_bad;
  logic [SHIFT_W-1:0] r_shift;
  logic [55:0]        r_base;
  logic [SIZE_W-1:0]  r_size;

  logic               l_valid, l_leaf, l_bad;
  logic [SHIFT_W-1:0] l_shift;
  logic [55:0]        l_base;
  logic [SIZE_W-1:0]  l_size;

  logic [63:0] prt_addr, lvl_addr;

  rw_root_decode #(.IDX_MIN(IDX_MIN), .IDX_MAX(IDX_MAX)) root_i (
    .prte       (entry_q),
    .va         (va_q),
    .seg_err    (r_seg),
    .bad_tree   (r_bad),
    .init_shift (r_shift),
    .root_base  (r_base),
    .root_size  (r_size)
  );

  rw_level_decode #(.IDX_MIN(IDX_MIN), .IDX_MAX(IDX_MAX)) level_i (
    .entry      (mem_rdata),
    .shift      (shift_q),
    .ent_valid  (l_valid),
    .ent_leaf   (l_leaf),
    .size_bad   (l_bad),
    .next_shift (l_shift),
    .next_base  (l_base),
    .next_size  (l_size)
  );

  rw_addr_calc calc_i (
    .va        (va_q),
    .pid       (pid_q),
    .ptbase    (ptbase_q),
    .lvl_base  (base_q),
    .lvl_size  (size_q),
    .shift     (shift_q),
    .leaf      (entry_q),
    .prt_addr  (prt_addr),
    .lvl_addr  (lvl_addr),
    .real_addr (real_addr)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    shift_d  = shift_q;
    size_d   = size_q;
    base_d   = base_q;
    err_d    = err_q;
    ld_req   = 1'b0;
    ld_walk  = 1'b0;
    ld_entry = 1'b0;
    ld_err   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          ld_err  = 1'b1;
          err_d   = ERR_NONE;
          state_d = ST_PRT_REQ;
        end
      end
      ST_PRT_REQ:  state_d = ST_PRT_WAIT;
      ST_PRT_WAIT: begin
        if (mem_rvalid) begin
          ld_entry = 1'b1;
          state_d  = ST_ROOT_CHK;
        end
      end
      ST_ROOT_CHK: begin
        if (r_seg) begin
          ld_err  = 1'b1;
          err_d   = ERR_SEG;
          state_d = ST_FINISH;
        end else if (r_bad) begin
          ld_err  = 1'b1;
          err_d   = ERR_BAD;
          state_d = ST_FINISH;
        end else begin
          ld_walk = 1'b1;
          shift_d = r_shift;
          size_d  = r_size;
          base_d  = r_base;
          state_d = ST_LVL_REQ;
        end
      end
      ST_LVL_REQ:  state_d = ST_LVL_WAIT;
      ST_LVL_WAIT: begin
        if (mem_rvalid) begin
          if (!l_valid) begin
            ld_err  = 1'b1;
            err_d   = ERR_INV;
            state_d = ST_FINISH;
          end else if (l_leaf) begin
            ld_entry = 1'b1;
            state_d  = ST_FINISH;
          end else if (l_bad) begin
            ld_err  = 1'b1;
            err_d   = ERR_BAD;
            state_d = ST_FINISH;
          end else begin
            ld_walk = 1'b1;
            shift_d = l_shift;
            size_d  = l_size;
            base_d  = l_base;
            state_d = ST_LVL_REQ;
          end
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      pid_q    <= '0;
      ptbase_q <= '0;
      shift_q  <= '0;
      size_q   <= '0;
      base_q   <= '0;
      entry_q  <= '0;
      err_q    <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        va_q     <= req_va;
        pid_q    <= req_pid;
        ptbase_q <= req_ptbase;
      end
      if (ld_walk) begin
        shift_q <= shift_d;
        size_q  <= size_d;
        base_q  <= base_d;
      end
      if (ld_entry) entry_q <= mem_rdata;
      if (ld_err)   err_q   <= err_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign done       = (state_q == ST_FINISH);
  assign mem_req    = (state_q == ST_PRT_REQ) || (state_q == ST_LVL_REQ);
  assign mem_addr   = (state_q == ST_PRT_REQ) ? prt_addr : lvl_addr;
  assign walk_err   = err_q;
  assign leaf_entry = entry_q;

  // R9
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(walk_err));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  // R4
  seg_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROOT_CHK && va_q[63] != va_q[62]) |=> (done && walk_err == ERR_SEG));

  // R5
  shift_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LVL_WAIT && mem_rvalid && mem_rdata[63] && !mem_rdata[62] && !l_bad)
      |=> (shift_q < $past(shift_q)));

endmodule

// File: tb/radix_walker_tb.sv
module radix_walker_tb_top;

  typedef struct packed {
    logic [63:0] va;
    logic [31:0] pid;
    logic [63:0] ptbase;
    logic [63:0] prte;
    logic [63:0] a_prt;
    logic [63:0] a_root;
    logic [63:0] e_root;
    logic [63:0] a_l2;
    logic [63:0] e_l2;
    logic [2:0]  err;
    logic [63:0] real_a;
    logic [3:0]  reads;
  } vec_t;

  localparam int NV = 12;
  localparam logic [63:0] PRTE_A = 64'h6000_0000_0030_000D;
  localparam logic [63:0] ROOT_A = 64'h8000_0000_0040_0009;
  localparam logic [63:0] LEAF_A = 64'hC000_0000_1234_5187;

  localparam vec_t VECS [NV] = '{
    // R2 R3 R6 R8 three-level walk
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h30_48D0, ROOT_A,
      64'h40_02B0, LEAF_A, 3'b000, 64'h1234_5187, 4'd3},
    // R2 top bit set, pid forced to zero
    '{64'hC000_0000_0020_3000, 32'd7, 64'h10_0000, PRTE_A, 64'h10_0000, 64'h30_0008, ROOT_A,
      64'h40_0018, 64'hC000_0000_0ABC_D0FF, 3'b000, 64'h0ABC_D0FF, 4'd3},
    // R4 bit 34 beyond tree size 3
    '{64'h4_0000_0000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h0, 64'h0,
      64'h0, 64'h0, 3'b010, 64'h0, 4'd1},
    // R4 top two bits differ
    '{64'h8000_0000_0000_0000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0000, 64'h0, 64'h0,
      64'h0, 64'h0, 3'b010, 64'h0, 4'd1},
    // R7 invalid root entry
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h30_48D0, 64'h0,
      64'h0, 64'h0, 3'b001, 64'h0, 4'd2},
    // R5 level width 4
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h30_48D0,
      64'h8000_0000_0040_0004, 64'h0, 64'h0, 3'b100, 64'h0, 4'd2},
    // R5 level width 10 above remaining 9
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h30_48D0,
      64'h8000_0000_0040_000A, 64'h0, 64'h0, 3'b100, 64'h0, 4'd2},
    // R5 root width 17
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, 64'h6000_0000_0030_0011, 64'h10_0050, 64'h0, 64'h0,
      64'h0, 64'h0, 3'b100, 64'h0, 4'd1},
    // R8 leaf at root level merges VA bits
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h30_48D0,
      64'hC000_0000_4000_0007, 64'h0, 64'h0, 3'b000, 64'h4005_6007, 4'd2},
    // R2 table size 4 mixes pid bits
    '{64'h1_2345_6000, 32'h123, 64'h20_0004, PRTE_A, 64'h20_1230, 64'h30_48D0, ROOT_A,
      64'h40_02B0, LEAF_A, 3'b000, 64'h1234_5187, 4'd3},
    // R7 invalid second-level entry
    '{64'h1_2345_6000, 32'd5, 64'h10_0000, PRTE_A, 64'h10_0050, 64'h30_48D0, ROOT_A,
      64'h40_02B0, 64'h0, 3'b001, 64'h0, 4'd3},
    // R3 R10 tree size 4 from upper fragment
    '{64'h4_0000_0000, 32'd5, 64'h10_0000, 64'h0000_0000_0030_002D, 64'h10_0050, 64'h30_8000,
      64'h8000_0000_0040_000A, 64'h40_0000, LEAF_A, 3'b000, 64'h1234_5187, 4'd3}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_va;
  logic [31:0] req_pid;
  logic [63:0] req_ptbase;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;
  logic        done;
  logic [2:0]  walk_err;
  logic [63:0] real_addr;
  logic [63:0] leaf_entry;

  radix_walker dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_va     (req_va),
    .req_pid    (req_pid),
    .req_ptbase (req_ptbase),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .walk_err   (walk_err),
    .real_addr  (real_addr),
    .leaf_entry (leaf_entry)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int   n_tests;
  int   n_fail;
  bit   finished;
  vec_t cur;
  int   lat;
  int   n_reads;
  bit   pend;
  bit   overlap;
  int   wait_cnt;
  logic [63:0] pend_addr;

  function automatic logic [63:0] lookup(input logic [63:0] a);
    if (a == cur.a_prt) return cur.prte;
    if (a == cur.a_root && cur.a_root != 64'h0) return cur.e_root;
    if (a == cur.a_l2 && cur.a_l2 != 64'h0) return cur.e_l2;
    return 64'h0;
  endfunction

  // memory responder, one read in flight
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      pend       <= 1'b0;
      overlap    <= 1'b0;
      n_reads    <= 0;
      wait_cnt   <= 0;
      pend_addr  <= '0;
    end else if (mem_req) begin
      if (pend) overlap <= 1'b1;
      pend       <= 1'b1;
      pend_addr  <= mem_addr;
      wait_cnt   <= lat;
      mem_rvalid <= 1'b0;
      n_reads    <= n_reads + 1;
    end else if (pend) begin
      if (wait_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= lookup(pend_addr);
        pend       <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic issue(input logic [63:0] va, input logic [31:0] pid, input logic [63:0] pt);
    @(negedge clk);
    req_valid  = 1'b1;
    req_va     = va;
    req_pid    = pid;
    req_ptbase = pt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input int k, input string tag);
    bit ok;
    int r0;
    cur = VECS[k];
    r0  = n_reads;
    issue(cur.va, cur.pid, cur.ptbase);
    wait_done(ok);
    check({tag, " done seen"}, 64'(ok), 64'd1);
    check({tag, " walk_err"}, 64'(walk_err), 64'(cur.err));
    if (cur.err == 3'b000) begin
      check({tag, " R8 real_addr"}, real_addr, cur.real_a);
      check({tag, " R8 leaf_entry"}, leaf_entry, (cur.reads == 4'd2) ? cur.e_root : cur.e_l2);
    end
    check({tag, " R6 read count"}, 64'(n_reads - r0), 64'(cur.reads));
    @(negedge clk);
    check({tag, " R10 done pulse"}, 64'(done), 64'd0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 1'b0;
    lat = 0; cur = VECS[0];
    req_valid = 1'b0; req_va = '0; req_pid = '0; req_ptbase = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 done", 64'(done), 64'd0);
    check("R1 mem_req", 64'(mem_req), 64'd0);

    for (int k = 0; k < NV; k++) begin
      run_vec(k, $sformatf("vec%0d", k));
    end

    // R9 long memory latency
    lat = 3;
    run_vec(0, "R9 latency3");
    run_vec(11, "R9 latency3 rts");
    lat = 0;

    // R10 request while busy is ignored
    cur = VECS[0];
    issue(cur.va, cur.pid, cur.ptbase);
    check("R10 busy ready", 64'(req_ready), 64'd0);
    req_valid = 1'b1; req_va = VECS[3].va;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      bit ok;
      wait_done(ok);
      check("R10 busy done", 64'(ok), 64'd1);
      check("R10 busy err", 64'(walk_err), 64'd0);
      check("R10 busy real", real_addr, cur.real_a);
    end
    @(negedge clk);
    check("R10 ready after", 64'(req_ready), 64'd1);
    repeat (3) @(negedge clk);
    check("R10 no stray walk", 64'(done), 64'd0);
    check("R9 one outstanding", 64'(overlap), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule